// File: doc/BRIEF.md
# Serial Port Control Registers with Receive Queue

This block is the register front end of an asynchronous serial port. A simple byte-wide register bus lets software set the line mode, the baud divisor, the control bits, a FIFO-control register and a port register, and read back a status word. Received bytes arrive from an external deserializer on a valid/data pair and are queued in a 16-entry receive FIFO. Software drains the queue through a receive-data register and can see its fill level in a count register. A write to the transmit-data register hands the byte to an external serializer as a one-cycle strobe.

The status word carries transmit-end, transmit-empty and receive-full flags. Software clears a flag by writing 0 to its bit, and a 1 in that bit leaves the flag alone. The receive-full flag follows the queue fill level against a trigger level chosen by two FIFO-control bits. A receive interrupt goes with that flag when it is enabled. The transmit interrupt follows a control bit directly. Reading the status word while the transmitter is enabled re-arms both transmit flags for the next read.

Register writes and the side effects of reads take effect at the rising clock edge where `bus_wr` or `bus_rd` is high. `bus_rdata` is combinational from the current address and state, so it is valid in the same cycle as `bus_rd`.

Top module: `serport_csr`

## Requirements
- R1: After reset the status word reads 0x60, control reads 0x20, baud reads 0xFF, FIFO-control and the receive count read 0, both interrupts are low, and the trigger level is 1.
- R2: Writes are masked before storage: the mode register (0x00) keeps bits 0x7B, control (0x08) keeps 0xFA, and the port register (0x20) keeps 0xF3. Baud (0x04) and FIFO-control (0x18) store and read back all 8 bits.
- R3: Received bytes are queued only while control bit 4 is 1. They read back in arrival order at 0x14, and 0x1C returns the current count. A byte that arrives while control bit 4 is 0 is ignored.
- R4: The queue holds 16 bytes. A byte that arrives when the queue is full is dropped, and the count stays at 16.
- R5: A read of 0x14 while the queue is empty returns 0 and changes no state.
- R6: FIFO-control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. Status bit 1 is set when a push leaves the count at or above the trigger, and it is cleared when a pop leaves the count below the trigger.
- R7: With control bit 6 set, the push that sets status bit 1 also raises `irq_rx`. `irq_rx` drops on a control write with bit 6 at 0, and on a status write with bit 1 or bit 0 at 0.
- R8: Status (0x10) has transmit-end at bit 6, transmit-empty at bit 5 and receive-full at bit 1. Bits 4 and 0 and all other bits read 0. A status write clears each flag whose bit is written as 0 and leaves the flag unchanged where the bit is 1.
- R9: A write to 0x0C gives `tx_valid` high for one cycle on the next cycle, with `tx_data` equal to the written byte. The same write clears transmit-empty.
- R10: A control write with bit 5 at 0 sets transmit-end. `irq_tx` follows stored control bit 7.
- R11: A status read returns the flags as they stood before the read. If control bit 5 is 1, the read then sets transmit-empty and transmit-end; if it is 0, the flags stay as they are.
- R12: Writing FIFO-control with bit 1 at 1 empties the queue and clears the receive-full flag. The trigger level is taken from the same write.
- R13: A push and a pop in the same cycle leave the count unchanged. The pop returns the oldest byte, and the receive-full flag is judged against the resulting count.
- R14: The line-status offset 0x24 reads 0 and ignores writes. Reads of the transmit-data offset and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; read side effects take effect at the clock edge |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe carrying a byte to transmit |
| tx_data | output | 8 | Byte to transmit |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The queue is driven with a short in-order burst, with an overfilled run of 17 bytes that checks dropping and ordering across the pointer wrap, and with reads of an empty queue. Each of the four trigger codes is approached one byte below and at its threshold, so that an off-by-one in the comparison or a swapped code shows up. Pushes that coincide with pops are placed both at and just below the trigger, which separates a design that uses the updated count from one that uses the stale count. Status writes with mixed ones and zeros, and status reads taken one after the other with the transmitter on and off, tell write-zero-to-clear apart from write-one-to-clear and show the timing of the re-arm relative to the returned value.

// File: rtl/serport_pkg.sv
package serport_pkg;

   localparam int unsigned BYTE_W = 8;

   // register offsets (byte addresses)
   localparam logic [7:0] OFS_MODE  = 8'h00;
   localparam logic [7:0] OFS_BAUD  = 8'h04;
   localparam logic [7:0] OFS_CTRL  = 8'h08;
   localparam logic [7:0] OFS_TXD   = 8'h0C;
   localparam logic [7:0] OFS_STAT  = 8'h10;
   localparam logic [7:0] OFS_RXD   = 8'h14;
   localparam logic [7:0] OFS_FCTL  = 8'h18;
   localparam logic [7:0] OFS_RXCNT = 8'h1C;
   localparam logic [7:0] OFS_PORT  = 8'h20;
   localparam logic [7:0] OFS_LINE  = 8'h24;

   // storage masks
   localparam logic [7:0] MODE_KEEP = 8'h7B;
   localparam logic [7:0] CTRL_KEEP = 8'hFA;
   localparam logic [7:0] PORT_KEEP = 8'hF3;

   // reset values
   localparam logic [7:0] BAUD_INIT = 8'hFF;
   localparam logic [7:0] CTRL_INIT = 8'h20;

   // control bit positions
   localparam int unsigned CB_RXEN = 4;
   localparam int unsigned CB_TXEN = 5;
   localparam int unsigned CB_RXIE = 6;
   localparam int unsigned CB_TXIE = 7;

   // status bit positions
   localparam int unsigned SB_TEND = 6;
   localparam int unsigned SB_TDE  = 5;
   localparam int unsigned SB_RDF  = 1;
   localparam int unsigned SB_DR   = 0;

   // FIFO-control fields
   localparam int unsigned FB_FLUSH  = 1;
   localparam int unsigned FB_TRG_LO = 6;

   typedef struct packed {
      logic tend;
      logic tde;
      logic rdf;
   } stat_flags_t;

endpackage

// File: rtl/serport_rx_fifo.sv
module serport_rx_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push_req,
   input  logic [DW-1:0] push_data,
   input  logic          pop_req,
   output logic [DW-1:0] head_data,
   output logic          push_ok,
   output logic          pop_ok,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_next
);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr, wptr_inc, rptr_inc;

   // pointer wrap: free for power-of-two depths, explicit compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wptr_inc = wptr + 1'b1;
      assign rptr_inc = rptr + 1'b1;
   end else begin : g_wrap_mod
      assign wptr_inc = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_inc = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   assign push_ok   = push_req && (count != CW'(DEPTH));
   assign pop_ok    = pop_req && (count != '0);
   assign head_data = (count != '0) ? mem[rptr] : '0;

   always_comb begin
      count_next = count;
      if (flush)
         count_next = '0;
      else if (push_ok && !pop_ok)
         count_next = count + 1'b1;
      else if (pop_ok && !push_ok)
         count_next = count - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         count <= count_next;
         if (flush) begin
            wptr <= '0;
            rptr <= '0;
         end else begin
            if (push_ok) wptr <= wptr_inc;
            if (pop_ok)  rptr <= rptr_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush)
         mem[wptr] <= push_data;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && (count == CW'(DEPTH)) && !pop_req && !flush |=> $stable(count)); // R4
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req && (count == '0) && !push_req && !flush |=> (count == '0)); // R5
   AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok && pop_ok && !flush |=> $stable(count)); // R13
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0)); // R12

endmodule

// File: rtl/serport_status.sv
module serport_status
   import serport_pkg::*;
#(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_wr,
   input  logic [3:0]    st_keep,    // written {bit6, bit5, bit1, bit0}
   input  logic          st_rd,
   input  logic          ctrl_wr,
   input  logic          ctrl_wr_te,
   input  logic          ctrl_wr_rie,
   input  logic          tx_wr,
   input  logic          tx_en,
   input  logic          rx_ie,
   input  logic          push_ok,
   input  logic          pop_ok,
   input  logic          flush,
   input  logic [CW-1:0] cnt_next,
   input  logic [CW-1:0] trig,
   output stat_flags_t   flags,
   output logic          irq_rx
);

   stat_flags_t flags_n;
   logic        irq_n;
   logic        at_trig;

   assign at_trig = (cnt_next >= trig);

   always_comb begin
      flags_n = flags;
      irq_n   = irq_rx;
      // transmit-empty
      if (st_rd && tx_en)   flags_n.tde = 1'b1;
      if (tx_wr)            flags_n.tde = 1'b0;
      if (st_wr && !st_keep[2]) flags_n.tde = 1'b0;
      // transmit-end
      if (st_rd && tx_en)   flags_n.tend = 1'b1;
      if (ctrl_wr && !ctrl_wr_te) flags_n.tend = 1'b1;
      if (st_wr && !st_keep[3]) flags_n.tend = 1'b0;
      // receive-full follows the updated count
      if (pop_ok && !at_trig)  flags_n.rdf = 1'b0;
      if (push_ok && at_trig)  flags_n.rdf = 1'b1;
      if (st_wr && !st_keep[1]) flags_n.rdf = 1'b0;
      if (flush)               flags_n.rdf = 1'b0;
      // receive interrupt: clears win over a same-cycle set
      if (push_ok && at_trig && rx_ie && !flush) irq_n = 1'b1;
      if (st_wr && (!st_keep[1] || !st_keep[0])) irq_n = 1'b0;
      if (ctrl_wr && !ctrl_wr_rie) irq_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags  <= '{tend: 1'b1, tde: 1'b1, rdf: 1'b0};
         irq_rx <= 1'b0;
      end else begin
         flags  <= flags_n;
         irq_rx <= irq_n;
      end
   end

   AST_TDE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr && !st_rd |=> !flags.tde); // R9
   AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd && tx_en && !st_wr |=> flags.tde && flags.tend); // R11
   AST_TEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !ctrl_wr_te |=> flags.tend); // R10
   AST_IRQ_NEEDS_RDF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_rx) |-> flags.rdf); // R7

endmodule

// File: rtl/serport_csr.sv
module serport_csr
   import serport_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned RXQ_DEPTH = 16,
   parameter int unsigned TRIG_L0   = 1,
   parameter int unsigned TRIG_L1   = 4,
   parameter int unsigned TRIG_L2   = 8,
   parameter int unsigned TRIG_L3   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              irq_rx,
   output logic              irq_tx
);

   localparam int unsigned CW = $clog2(RXQ_DEPTH + 1);

   // elaboration-time parameter checks
   if (ADDR_W < 6) begin : g_chk_addr
      $error("serport_csr: ADDR_W must cover offset 0x24");
   end
   if (RXQ_DEPTH < 2 || CW > BYTE_W) begin : g_chk_depth
      $error("serport_csr: RXQ_DEPTH out of range");
   end
   if (TRIG_L0 < 1 || TRIG_L1 < 1 || TRIG_L2 < 1 || TRIG_L3 < 1 ||
       TRIG_L0 > RXQ_DEPTH || TRIG_L1 > RXQ_DEPTH ||
       TRIG_L2 > RXQ_DEPTH || TRIG_L3 > RXQ_DEPTH) begin : g_chk_trig
      $error("serport_csr: trigger levels must lie in 1..RXQ_DEPTH");
   end

   logic [7:0] mode_q, baud_q, ctrl_q, fctl_q, port_q;
   logic hit_mode, hit_baud, hit_ctrl, hit_txd, hit_stat, hit_rxd, hit_fctl, hit_cnt, hit_port;
   logic wr_ctrl, wr_stat, wr_fctl, wr_tx, rd_stat, flush;
   logic [CW-1:0] trig_lvl, q_cnt, q_cnt_next;
   logic [7:0]    q_head;
   logic          push_ok, pop_ok;
   stat_flags_t   flags;
   logic [7:0]    stat_word;

   assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
   assign hit_baud = (bus_addr == ADDR_W'(OFS_BAUD));
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_txd  = (bus_addr == ADDR_W'(OFS_TXD));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
   assign hit_fctl = (bus_addr == ADDR_W'(OFS_FCTL));
   assign hit_cnt  = (bus_addr == ADDR_W'(OFS_RXCNT));
   assign hit_port = (bus_addr == ADDR_W'(OFS_PORT));

   assign wr_ctrl = bus_wr && hit_ctrl;
   assign wr_stat = bus_wr && hit_stat;
   assign wr_fctl = bus_wr && hit_fctl;
   assign wr_tx   = bus_wr && hit_txd;
   assign rd_stat = bus_rd && hit_stat;
   assign flush   = wr_fctl && bus_wdata[FB_FLUSH];

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         baud_q <= BAUD_INIT;
         ctrl_q <= CTRL_INIT;
         fctl_q <= '0;
         port_q <= '0;
      end else if (bus_wr) begin
         if (hit_mode) mode_q <= bus_wdata & MODE_KEEP;
         if (hit_baud) baud_q <= bus_wdata;
         if (hit_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
         if (hit_fctl) fctl_q <= bus_wdata;
         if (hit_port) port_q <= bus_wdata & PORT_KEEP;
      end
   end

   always_comb begin
      unique case (fctl_q[FB_TRG_LO +: 2])
         2'd0:    trig_lvl = CW'(TRIG_L0);
         2'd1:    trig_lvl = CW'(TRIG_L1);
         2'd2:    trig_lvl = CW'(TRIG_L2);
         default: trig_lvl = CW'(TRIG_L3);
      endcase
   end

   serport_rx_fifo #(.DEPTH(RXQ_DEPTH), .DW(BYTE_W)) u_rxq (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .push_req   (rx_valid && ctrl_q[CB_RXEN]),
      .push_data  (rx_data),
      .pop_req    (bus_rd && hit_rxd),
      .head_data  (q_head),
      .push_ok    (push_ok),
      .pop_ok     (pop_ok),
      .count      (q_cnt),
      .count_next (q_cnt_next)
   );

   serport_status #(.CW(CW)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .st_wr       (wr_stat),
      .st_keep     ({bus_wdata[SB_TEND], bus_wdata[SB_TDE], bus_wdata[SB_RDF], bus_wdata[SB_DR]}),
      .st_rd       (rd_stat),
      .ctrl_wr     (wr_ctrl),
      .ctrl_wr_te  (bus_wdata[CB_TXEN]),
      .ctrl_wr_rie (bus_wdata[CB_RXIE]),
      .tx_wr       (wr_tx),
      .tx_en       (ctrl_q[CB_TXEN]),
      .rx_ie       (ctrl_q[CB_RXIE]),
      .push_ok     (push_ok),
      .pop_ok      (pop_ok),
      .flush       (flush),
      .cnt_next    (q_cnt_next),
      .trig        (trig_lvl),
      .flags       (flags),
      .irq_rx      (irq_rx)
   );

   // transmit strobe toward the serializer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= wr_tx;
         if (wr_tx) tx_data <= bus_wdata;
      end
   end

   assign irq_tx = ctrl_q[CB_TXIE];

   always_comb begin
      stat_word          = '0;
      stat_word[SB_TEND] = flags.tend;
      stat_word[SB_TDE]  = flags.tde;
      stat_word[SB_RDF]  = flags.rdf;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_mode)      bus_rdata = mode_q;
      else if (hit_baud) bus_rdata = baud_q;
      else if (hit_ctrl) bus_rdata = ctrl_q;
      else if (hit_stat) bus_rdata = stat_word;
      else if (hit_rxd)  bus_rdata = q_head;
      else if (hit_fctl) bus_rdata = fctl_q;
      else if (hit_cnt)  bus_rdata = 8'(q_cnt);
      else if (hit_port) bus_rdata = port_q;
   end

   AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_tx |=> tx_valid && (tx_data == $past(bus_wdata))); // R9
   AST_TX_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (irq_tx == $past(bus_wdata[CB_TXIE]))); // R10
   AST_RDF_AT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok && !wr_stat && !wr_fctl |=> (q_cnt < trig_lvl) || flags.rdf); // R6
   AST_IRQ_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && !bus_wdata[CB_RXIE] |=> !irq_rx); // R7
   AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !ctrl_q[CB_RXEN] && !bus_rd && !bus_wr |=> $stable(q_cnt)); // R3

endmodule

// File: tb/tb_serport_csr.sv
`timescale 1ns/1ps
module tb_serport_csr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       irq_rx, irq_tx;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   serport_csr dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
      .tx_data(tx_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   localparam logic [5:0] A_MODE = 6'h00, A_BAUD = 6'h04, A_CTRL = 6'h08,
      A_TXD = 6'h0C, A_STAT = 6'h10, A_RXD = 6'h14, A_FCTL = 6'h18,
      A_CNT = 6'h1C, A_PORT = 6'h20, A_LINE = 6'h24;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic expect_rd(input string req, input logic [5:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic push_pop(input string req, input logic [7:0] b, input logic [7:0] exp_head);
      logic [7:0] v;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; bus_addr = A_RXD; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      rx_valid = 1'b0; bus_rd = 1'b0;
      check(req, v, exp_head);
   endtask

   task automatic tx_send(input string req, input logic [7:0] b);
      @(negedge clk);
      bus_addr = A_TXD; bus_wdata = b; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      check({req, " strobe"}, {7'd0, tx_valid}, 8'h01);
      check({req, " data"}, tx_data, b);
      @(negedge clk);
      check({req, " strobe width"}, {7'd0, tx_valid}, 8'h00);
   endtask

   task automatic t_reset;
      check("R1 irq_rx", {7'd0, irq_rx}, 8'h00);
      check("R1 irq_tx", {7'd0, irq_tx}, 8'h00);
      check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
      expect_rd("R1 status", A_STAT, 8'h60);
      expect_rd("R1 control", A_CTRL, 8'h20);
      expect_rd("R1 baud", A_BAUD, 8'hFF);
      expect_rd("R1 fifo-control", A_FCTL, 8'h00);
      expect_rd("R1 count", A_CNT, 8'h00);
   endtask

   task automatic t_masks;
      wr(A_MODE, 8'hFF); expect_rd("R2 mode mask", A_MODE, 8'h7B);
      wr(A_PORT, 8'hFF); expect_rd("R2 port mask", A_PORT, 8'hF3);
      wr(A_BAUD, 8'h5A); expect_rd("R2 baud", A_BAUD, 8'h5A);
      wr(A_CTRL, 8'hFF); expect_rd("R2 control mask", A_CTRL, 8'hFA);
      check("R10 irq_tx on", {7'd0, irq_tx}, 8'h01);
      wr(A_CTRL, 8'h30);
      check("R10 irq_tx off", {7'd0, irq_tx}, 8'h00);
   endtask

   task automatic t_rx_order;
      push(8'h11);
      expect_rd("R1 trigger level 1", A_STAT, 8'h62);
      push(8'h22); push(8'h33);
      expect_rd("R3 count", A_CNT, 8'h03);
      expect_rd("R3 order 1", A_RXD, 8'h11);
      expect_rd("R3 order 2", A_RXD, 8'h22);
      expect_rd("R3 order 3", A_RXD, 8'h33);
      expect_rd("R3 count drained", A_CNT, 8'h00);
      wr(A_CTRL, 8'h20);
      push(8'h44);
      expect_rd("R3 disabled receive ignored", A_CNT, 8'h00);
      wr(A_CTRL, 8'h30);
   endtask

   task automatic t_empty;
      expect_rd("R5 empty read", A_RXD, 8'h00);
      expect_rd("R5 count unchanged", A_CNT, 8'h00);
      expect_rd("R5 status unchanged", A_STAT, 8'h60);
   endtask

   task automatic t_full;
      for (int i = 0; i < 17; i++) push(8'(i + 1));
      expect_rd("R4 count at full", A_CNT, 8'h10);
      for (int i = 0; i < 16; i++) expect_rd("R4 order across wrap", A_RXD, 8'(i + 1));
      expect_rd("R4 dropped byte absent", A_RXD, 8'h00);
      expect_rd("R4 count empty", A_CNT, 8'h00);
   endtask

   task automatic t_trigger;
      wr(A_FCTL, 8'h82);                          // flush, trigger 8
      for (int i = 0; i < 7; i++) push(8'hA0 + 8'(i));
      expect_rd("R6 below trigger 8", A_STAT, 8'h60);
      push(8'hA7);
      expect_rd("R6 at trigger 8", A_STAT, 8'h62);
      expect_rd("R6 pop head", A_RXD, 8'hA0);
      expect_rd("R6 pop below trigger", A_STAT, 8'h60);
      wr(A_CTRL, 8'h70);
      push(8'hA8);
      check("R7 irq with flag", {7'd0, irq_rx}, 8'h01);
      wr(A_STAT, 8'hFE);
      check("R7 status bit0 zero drops irq", {7'd0, irq_rx}, 8'h00);
      expect_rd("R8 ones keep flags", A_STAT, 8'h62);
      wr(A_STAT, 8'hFD);
      expect_rd("R8 zero clears receive-full", A_STAT, 8'h60);
      wr(A_FCTL, 8'h02);                          // flush, trigger 1
      expect_rd("R12 flush count", A_CNT, 8'h00);
      expect_rd("R12 flush flag", A_STAT, 8'h60);
      push(8'hB0);
      check("R7 irq trigger 1", {7'd0, irq_rx}, 8'h01);
      wr(A_CTRL, 8'h30);
      check("R7 control bit6 zero drops irq", {7'd0, irq_rx}, 8'h00);
      wr(A_CTRL, 8'h70);
      push(8'hB1);
      check("R7 irq again", {7'd0, irq_rx}, 8'h01);
      wr(A_STAT, 8'hFD);
      check("R7 status bit1 zero drops irq", {7'd0, irq_rx}, 8'h00);
      wr(A_CTRL, 8'h30);
      wr(A_FCTL, 8'hC2);                          // flush, trigger 14
      for (int i = 0; i < 13; i++) push(8'(i));
      expect_rd("R6 below trigger 14", A_STAT, 8'h60);
      push(8'h0D);
      expect_rd("R6 at trigger 14", A_STAT, 8'h62);
      wr(A_FCTL, 8'h42);                          // flush, trigger 4
      expect_rd("R12 fifo-control readback", A_FCTL, 8'h42);
      for (int i = 0; i < 3; i++) push(8'h50 + 8'(i));
      expect_rd("R6 below trigger 4", A_STAT, 8'h60);
      push(8'h53);
      expect_rd("R6 at trigger 4", A_STAT, 8'h62);
   endtask

   task automatic t_same_cycle;
      push_pop("R13 head on push+pop", 8'h99, 8'h50);
      expect_rd("R13 count held", A_CNT, 8'h04);
      expect_rd("R13 flag at updated count", A_STAT, 8'h62);
      expect_rd("R13 pop", A_RXD, 8'h51);
      expect_rd("R13 below trigger", A_STAT, 8'h60);
      push_pop("R13 head below trigger", 8'h9A, 8'h52);
      expect_rd("R13 count held below", A_CNT, 8'h03);
      expect_rd("R13 flag stays clear", A_STAT, 8'h60);
      expect_rd("R13 order 1", A_RXD, 8'h53);
      expect_rd("R13 order 2", A_RXD, 8'h99);
      expect_rd("R13 order 3", A_RXD, 8'h9A);
   endtask

   task automatic t_transmit;
      tx_send("R9 tx A5", 8'hA5);
      expect_rd("R11 read shows cleared empty", A_STAT, 8'h40);
      expect_rd("R11 rearmed", A_STAT, 8'h60);
      wr(A_STAT, 8'h00);
      expect_rd("R8 all cleared", A_STAT, 8'h00);
      expect_rd("R11 rearm after clear", A_STAT, 8'h60);
      wr(A_STAT, 8'h20);
      expect_rd("R8 clear end only", A_STAT, 8'h20);
      wr(A_STAT, 8'h00);
      wr(A_CTRL, 8'h10);
      expect_rd("R10 transmit-end set", A_STAT, 8'h40);
      expect_rd("R11 no rearm when disabled", A_STAT, 8'h40);
      tx_send("R9 tx 3C", 8'h3C);
      expect_rd("R11 still disabled", A_STAT, 8'h40);
   endtask

   task automatic t_line;
      wr(A_LINE, 8'hFF);
      expect_rd("R14 line status", A_LINE, 8'h00);
      expect_rd("R14 tx offset read", A_TXD, 8'h00);
      expect_rd("R14 unmapped read", 6'h3C, 8'h00);
      expect_rd("R14 status untouched", A_STAT, 8'h40);
      expect_rd("R14 mode untouched", A_MODE, 8'h7B);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masks();
      t_rx_order();
      t_empty();
      t_full();
      t_trigger();
      t_same_cycle();
      t_transmit();
      t_line();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule